// File: doc/BRIEF.md
# Down-Counting Compare Timer

This block is a 32-bit periodic timer driven through a small memory-mapped register set on a simple synchronous bus (address, write strobe, write data, combinational read data). A counter runs downward on prescaled ticks. The ticks come from one of several external tick-enable inputs, and a source value of zero turns them off. When the counter reaches zero it either reloads from a separate load register or rolls over to all ones.

Each time a tick moves the counter onto the value held in the compare register, a sticky flag is set. Software clears the flag by writing one to it. The flag, gated by an enable bit, forms the interrupt. The same match event drives an output pin in one of four modes. A system timer uses the block by parking the load register at all ones and moving the compare value ahead of the running count.

Top module: `dcount_timer`

## Requirements
- R1: Register word offsets are control 0x00, status 0x04, load 0x08, compare 0x0C and counter 0x10 (read only). After reset, control, compare and status read 0, while load and counter read 0xFFFFFFFF. Control keeps only the bits in mask 0x03EEFFFF, so bits 16, 20 and 26-31 read 0.
- R2: Control bits 25:24 select the tick source. Value 0 means no tick and the counter is frozen. Value k (1..3) uses tickIn[k-1]. Other inputs have no effect.
- R3: With enable (control bit 0) set, the counter falls by one on each tick. A tick occurs every (P+1) clock cycles in which the chosen source is high, where P is control bits 15:4.
- R4: With reload (control bit 3) set, a tick at count 0 loads the load register value into the counter.
- R5: With reload clear, a tick at count 0 moves the counter to 0xFFFFFFFF.
- R6: A control write that sets enable while it was clear, with enable-mode (bit 1) set in the same write, starts the counter from the load register. With enable-mode clear, the counter resumes from its held value.
- R7: Status bit 0 is set on the clock edge where a tick moves the counter to the compare value. It stays set until a status write with bit 0 at 1. A status write with bit 0 at 0 leaves it set.
- R8: irqOut is high exactly when the status flag and the interrupt enable (control bit 2) are both set. Clearing the enable does not clear the flag.
- R9: Control bits 23:22 set the pin mode on a match: 0 holds cmpPin low, 1 toggles it, 2 drives it low, 3 drives it high.
- R10: With overwrite (control bit 17) set, a write to the load register also sets the counter to the written value. With it clear, the counter is untouched.
- R11: A control write with bit 16 set returns every register, the flag and the pin to their reset values on that edge.
- R12: With enable clear, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 5 | Byte address of the register |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| tickIn | input | 3 | External tick-enable inputs |
| irqOut | output | 1 | Gated compare interrupt |
| cmpPin | output | 1 | Compare output pin |

## Verification
Read data is combinational, so a register write shows on the bus as soon as the edge that takes it has passed. A counter step, flag set or pin change lands on the edge of the tick that causes it. The bench drives and samples only on falling edges and counts the rising edges in between. From that count, the prescale value and the load value, it computes each expected count, flag and pin level arithmetically. A control write that clears enable still takes the tick on its own edge, and the expected values include that step.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int PRE_W = 12;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_LOAD = 'h08;
  localparam int OFS_CMP  = 'h0C;
  localparam int OFS_CNT  = 'h10;

  localparam int B_EN    = 0;
  localparam int B_ENMOD = 1;
  localparam int B_IEN   = 2;
  localparam int B_RLD   = 3;
  localparam int B_PRE   = 4;
  localparam int B_SWR   = 16;
  localparam int B_IOVW  = 17;
  localparam int B_OM    = 22;
  localparam int B_SRC   = 24;
  localparam logic [31:0] CTRL_KEEP = 32'h03EE_FFFF;

  typedef struct packed {
    logic loadCnt;
    logic startCnt;
    logic swReset;
    logic clrFlag;
  } strobe_t;

  typedef struct packed {
    logic       enable;
    logic       reload;
    logic       irqEn;
    logic [1:0] srcSel;
    logic [1:0] outMode;
  } cfg_t;
endpackage

// File: rtl/tmr_ctrl.sv
`timescale 1ns/1ps
module tmr_ctrl import tmr_pkg::*; #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [AW-1:0]    busAddr,
  input  logic             busWe,
  input  logic [DW-1:0]    busWdata,
  output logic [DW-1:0]    busRdata,
  input  logic [DW-1:0]    cntVal,
  input  logic             flag,
  output strobe_t          stb,
  output cfg_t             cfg,
  output logic [PRE_W-1:0] presc,
  output logic [DW-1:0]    loadVal,
  output logic [DW-1:0]    cmpVal
);
  localparam logic [DW-1:0] KEEP = DW'(CTRL_KEEP);

  logic [DW-1:0] ctrlReg, loadReg, cmpReg;
  logic wrCtrl, wrStat, wrLoad, wrCmp;

  assign wrCtrl = busWe && (busAddr == AW'(OFS_CTRL));
  assign wrStat = busWe && (busAddr == AW'(OFS_STAT));
  assign wrLoad = busWe && (busAddr == AW'(OFS_LOAD));
  assign wrCmp  = busWe && (busAddr == AW'(OFS_CMP));

  assign stb.swReset  = wrCtrl && busWdata[B_SWR];
  assign stb.startCnt = wrCtrl && !busWdata[B_SWR] && busWdata[B_EN]
                        && busWdata[B_ENMOD] && !ctrlReg[B_EN];
  assign stb.loadCnt  = wrLoad && ctrlReg[B_IOVW];
  assign stb.clrFlag  = wrStat && busWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      loadReg <= '1;
      cmpReg  <= '0;
    end else if (stb.swReset) begin
      ctrlReg <= '0;
      loadReg <= '1;
      cmpReg  <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= busWdata & KEEP;
      if (wrLoad) loadReg <= busWdata;
      if (wrCmp)  cmpReg  <= busWdata;
    end
  end

  assign cfg.enable  = ctrlReg[B_EN];
  assign cfg.reload  = ctrlReg[B_RLD];
  assign cfg.irqEn   = ctrlReg[B_IEN];
  assign cfg.srcSel  = ctrlReg[B_SRC +: 2];
  assign cfg.outMode = ctrlReg[B_OM +: 2];
  assign presc       = ctrlReg[B_PRE +: PRE_W];
  assign loadVal     = loadReg;
  assign cmpVal      = cmpReg;

  always_comb begin
    busRdata = '0;
    if      (busAddr == AW'(OFS_CTRL)) busRdata = ctrlReg;
    else if (busAddr == AW'(OFS_STAT)) busRdata = {{(DW-1){1'b0}}, flag};
    else if (busAddr == AW'(OFS_LOAD)) busRdata = loadReg;
    else if (busAddr == AW'(OFS_CMP))  busRdata = cmpReg;
    else if (busAddr == AW'(OFS_CNT))  busRdata = cntVal;
  end

  // R11: software reset leaves the registers at reset values
  p_swr_regs_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.swReset |=> (ctrlReg == '0 && loadReg == '1 && cmpReg == '0));

  // R1: reserved control bits never hold a one
  p_ctrl_keep_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> ((ctrlReg & ~KEEP) == '0));
endmodule

// File: rtl/tmr_dpath.sv
`timescale 1ns/1ps
module tmr_dpath import tmr_pkg::*; #(
  parameter int DW   = 32,
  parameter int NSRC = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  cfg_t             cfg,
  input  logic [PRE_W-1:0] presc,
  input  logic [DW-1:0]    loadVal,
  input  logic [DW-1:0]    cmpVal,
  input  logic [DW-1:0]    busWdata,
  input  logic [NSRC-1:0]  tickIn,
  output logic [DW-1:0]    cntVal,
  output logic             flag,
  output logic             irq,
  output logic             pinOut
);
  logic [PRE_W-1:0] preCnt;
  logic [DW-1:0]    cntReg, cntNext;
  logic             srcTick, srcEn, tick, hit, flagReg, pinReg, quiet;

  always_comb begin
    srcTick = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (cfg.srcSel == 2'(i + 1)) srcTick = tickIn[i];
  end

  assign srcEn   = cfg.enable && srcTick;
  assign tick    = srcEn && (preCnt >= presc);
  assign quiet   = !stb.loadCnt && !stb.startCnt && !stb.swReset;
  assign cntNext = (cntReg == '0) ? (cfg.reload ? loadVal : '1) : cntReg - 1'b1;
  assign hit     = tick && quiet && (cntNext == cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            preCnt <= '0;
    else if (stb.swReset || stb.startCnt) preCnt <= '0;
    else if (srcEn)                       preCnt <= tick ? '0 : preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntReg <= '1;
    else if (stb.swReset)  cntReg <= '1;
    else if (stb.loadCnt)  cntReg <= busWdata;
    else if (stb.startCnt) cntReg <= loadVal;
    else if (tick)         cntReg <= cntNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            flagReg <= 1'b0;
    else if (stb.swReset) flagReg <= 1'b0;
    else if (hit)         flagReg <= 1'b1;
    else if (stb.clrFlag) flagReg <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pinReg <= 1'b0;
    else if (stb.swReset) pinReg <= 1'b0;
    else if (hit) begin
      case (cfg.outMode)
        2'd1:    pinReg <= ~pinReg;
        2'd2:    pinReg <= 1'b0;
        2'd3:    pinReg <= 1'b1;
        default: pinReg <= pinReg;
      endcase
    end
  end

  assign cntVal = cntReg;
  assign flag   = flagReg;
  assign irq    = flagReg && cfg.irqEn;
  assign pinOut = (cfg.outMode == 2'd0) ? 1'b0 : pinReg;

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.srcSel == 2'd0 && quiet) |=> $stable(cntReg));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.enable && quiet) |=> $stable(cntReg));

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && quiet && cntReg != '0) |=> (cntReg == $past(cntReg) - 1'b1));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && quiet && cntReg == '0 && !cfg.reload) |=> (cntReg == '1));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg && !stb.clrFlag && !stb.swReset) |=> flagReg);

  p_swr_state_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.swReset |=> (cntReg == '1 && !flagReg && !pinReg));
endmodule

// File: rtl/dcount_timer.sv
`timescale 1ns/1ps
module dcount_timer import tmr_pkg::*; #(
  parameter int DW   = 32,
  parameter int AW   = 5,
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [AW-1:0]   busAddr,
  input  logic            busWe,
  input  logic [DW-1:0]   busWdata,
  output logic [DW-1:0]   busRdata,
  input  logic [NSRC-1:0] tickIn,
  output logic            irqOut,
  output logic            cmpPin
);
  strobe_t          stb;
  cfg_t             cfg;
  logic [PRE_W-1:0] presc;
  logic [DW-1:0]    loadVal, cmpVal, cntVal;
  logic             flag;

  tmr_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .cntVal(cntVal), .flag(flag),
    .stb(stb), .cfg(cfg), .presc(presc), .loadVal(loadVal), .cmpVal(cmpVal)
  );

  tmr_dpath #(.DW(DW), .NSRC(NSRC)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .cfg(cfg), .presc(presc),
    .loadVal(loadVal), .cmpVal(cmpVal), .busWdata(busWdata), .tickIn(tickIn),
    .cntVal(cntVal), .flag(flag), .irq(irqOut), .pinOut(cmpPin)
  );
endmodule

// File: tb/sim_dcount_timer.sv
`timescale 1ns/1ps
module sim_dcount_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  tickIn = 3'b001;
  logic        irqOut, cmpPin;
  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                         A_CMP = 5'h0C, A_CNT = 5'h10;
  localparam logic [31:0] EN = 32'h1, ENMOD = 32'h2, IEN = 32'h4, RLD = 32'h8,
                          SWR = 32'h1_0000, IOVW = 32'h2_0000,
                          SRC1 = 32'h0100_0000, SRC2 = 32'h0200_0000;

  dcount_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .tickIn(tickIn),
    .irqOut(irqOut), .cmpPin(cmpPin)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  function automatic logic [31:0] om(input int m);
    return 32'(m) << 22;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    #500000;
    nChk++; nFail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset values
    rd(A_CTRL, v); chk("R1 ctrl reset", v, 32'h0);
    rd(A_STAT, v); chk("R1 stat reset", v, 32'h0);
    rd(A_LOAD, v); chk("R1 load reset", v, 32'hFFFF_FFFF);
    rd(A_CMP, v);  chk("R1 cmp reset", v, 32'h0);
    rd(A_CNT, v);  chk("R1 cnt reset", v, 32'hFFFF_FFFF);
    chk("R8 irq reset", {31'b0, irqOut}, 32'h0);
    chk("R9 pin reset", {31'b0, cmpPin}, 32'h0);

    // R3: prescaler sweep
    for (int p = 0; p < 4; p++) begin
      wr(A_CTRL, SWR);
      wr(A_LOAD, 32'd1000);
      wr(A_CTRL, EN | ENMOD | SRC1 | (32'(p) << 4));
      for (int n = 0; n <= 12; n++) begin
        rd(A_CNT, v);
        chk($sformatf("R3 presc=%0d n=%0d", p, n), v, 32'd1000 - 32'(n / (p + 1)));
        @(negedge clk);
      end
    end

    // R4: reload from load register
    wr(A_CTRL, SWR);
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, EN | ENMOD | RLD | SRC1);
    for (int n = 0; n <= 10; n++) begin
      rd(A_CNT, v);
      chk($sformatf("R4 n=%0d", n), v, 32'd3 - 32'(n % 4));
      @(negedge clk);
    end

    // R5: rollover to all ones
    wr(A_CTRL, SWR);
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, EN | ENMOD | SRC1);
    for (int n = 0; n <= 6; n++) begin
      rd(A_CNT, v);
      chk($sformatf("R5 n=%0d", n), v, 32'd2 - 32'(n));
      @(negedge clk);
    end

    // R6 / R12: hold, resume, restart
    wr(A_CTRL, SWR);
    wr(A_LOAD, 32'd100);
    wr(A_CTRL, EN | ENMOD | SRC1);
    repeat (5) @(negedge clk);
    wr(A_CTRL, SRC1);              // tick still taken on this edge
    rd(A_CNT, v); chk("R12 after disable", v, 32'd94);
    repeat (6) @(negedge clk);
    rd(A_CNT, v); chk("R12 held", v, 32'd94);
    wr(A_CTRL, EN | SRC1);
    rd(A_CNT, v); chk("R6 resume", v, 32'd94);
    repeat (3) @(negedge clk);
    rd(A_CNT, v); chk("R6 resume counting", v, 32'd91);
    wr(A_CTRL, SRC1);
    wr(A_CTRL, EN | ENMOD | SRC1);
    rd(A_CNT, v); chk("R6 restart from load", v, 32'd100);

    // R2: source selection
    wr(A_CTRL, SWR);
    wr(A_LOAD, 32'd50);
    wr(A_CTRL, EN | ENMOD);
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R2 source off frozen", v, 32'd50);
    wr(A_CTRL, EN | SRC2);
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R2 other input ignored", v, 32'd50);
    tickIn = 3'b011;
    repeat (3) @(negedge clk);
    tickIn = 3'b001;
    rd(A_CNT, v); chk("R2 selected input", v, 32'd47);

    // R7 / R8: compare flag and interrupt
    wr(A_CTRL, SWR);
    wr(A_LOAD, 32'd10);
    wr(A_CMP, 32'd6);
    wr(A_CTRL, EN | ENMOD | IEN | SRC1);
    for (int n = 0; n <= 5; n++) begin
      rd(A_STAT, v);
      chk($sformatf("R7 flag n=%0d", n), v, (n >= 4) ? 32'd1 : 32'd0);
      chk($sformatf("R8 irq n=%0d", n), {31'b0, irqOut}, (n >= 4) ? 32'd1 : 32'd0);
      @(negedge clk);
    end
    wr(A_CTRL, IEN | SRC1);
    rd(A_STAT, v); chk("R7 flag sticky", v, 32'd1);
    wr(A_CTRL, SRC1);
    chk("R8 irq masked", {31'b0, irqOut}, 32'd0);
    rd(A_STAT, v); chk("R8 flag kept when masked", v, 32'd1);
    wr(A_STAT, 32'd0);
    rd(A_STAT, v); chk("R7 write zero no effect", v, 32'd1);
    wr(A_STAT, 32'd1);
    rd(A_STAT, v); chk("R7 write one clears", v, 32'd0);
    wr(A_CTRL, IEN | SRC1);
    chk("R8 irq low with flag clear", {31'b0, irqOut}, 32'd0);

    // R9: toggle mode
    wr(A_CTRL, SWR);
    wr(A_LOAD, 32'd3);
    wr(A_CMP, 32'd1);
    wr(A_CTRL, EN | ENMOD | RLD | SRC1 | om(1));
    for (int n = 0; n <= 12; n++) begin
      int tg;
      tg = (n >= 2) ? ((n - 2) / 4 + 1) : 0;
      chk($sformatf("R9 toggle n=%0d", n), {31'b0, cmpPin}, 32'(tg % 2));
      @(negedge clk);
    end
    // R9: set mode
    wr(A_CTRL, SWR);
    wr(A_LOAD, 32'd3);
    wr(A_CMP, 32'd1);
    wr(A_CTRL, EN | ENMOD | RLD | SRC1 | om(3));
    for (int n = 0; n <= 6; n++) begin
      chk($sformatf("R9 set n=%0d", n), {31'b0, cmpPin}, (n >= 2) ? 32'd1 : 32'd0);
      @(negedge clk);
    end
    wr(A_CTRL, EN | RLD | SRC1 | om(0));
    chk("R9 disconnected low", {31'b0, cmpPin}, 32'd0);
    repeat (5) @(negedge clk);
    chk("R9 disconnected stays low", {31'b0, cmpPin}, 32'd0);
    wr(A_CTRL, EN | RLD | SRC1 | om(2));
    repeat (8) @(negedge clk);
    chk("R9 clear mode", {31'b0, cmpPin}, 32'd0);

    // R10: overwrite on load
    wr(A_CTRL, SWR);
    wr(A_CTRL, IOVW);
    wr(A_LOAD, 32'd77);
    rd(A_CNT, v); chk("R10 overwrite", v, 32'd77);
    wr(A_CTRL, 32'd0);
    wr(A_LOAD, 32'd55);
    rd(A_CNT, v); chk("R10 no overwrite", v, 32'd77);
    rd(A_LOAD, v); chk("R10 load stored", v, 32'd55);

    // R1: control readback mask; R11: software reset
    wr(A_CMP, 32'd5);
    wr(A_CTRL, 32'hFFFE_FFFF);
    rd(A_CTRL, v); chk("R1 ctrl mask", v, 32'h03EE_FFFF);
    wr(A_CTRL, SWR | EN);
    rd(A_CTRL, v); chk("R11 ctrl cleared", v, 32'h0);
    rd(A_LOAD, v); chk("R11 load cleared", v, 32'hFFFF_FFFF);
    rd(A_CMP, v);  chk("R11 cmp cleared", v, 32'h0);
    rd(A_CNT, v);  chk("R11 cnt cleared", v, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R11 stat cleared", v, 32'h0);

    summary();
  end
endmodule